// File: doc/BRIEF.md
# TV Audio Decoder Control Port (Two-Wire Serial Slave)

This block is the serial control port of a TV sound decoder. It listens on a two-wire serial bus (SCL clock, SDA data), oversampled by the system clock. It recognises its own 7-bit device address and accepts write frames into a small bank of 8-bit control registers. It also answers read frames with a status byte taken from two detector flags. The detector flags come in as plain inputs. The register contents go out as a flat vector, and a dedicated output carries the two automatic-gain mode bits.

A write frame has three parts: the address byte, a sub-address byte, and one or more data bytes. Bit 7 of the sub-address selects the multi-byte behaviour. When it is clear, each data byte lands in the next slot. When it is set, every data byte rewrites the same slot. A read frame has no sub-address: one status byte follows the address acknowledge directly. SDA is never driven high. The block only asserts an active-low pull enable, so the line keeps its open-drain behaviour.

Top module: `tvctl_i2c_slave`

## Requirements
- R1: After reset, every control register reads 0x00, `agc_mode_o` is 0 and `sda_pull_o` is 0 (SDA released).
- R2: A frame that starts with address byte 0xB6 (device bits 1011011, R/W=0) gets an ACK (SDA pulled low during the ninth clock) for the address byte, the sub-address byte and every data byte. Registers change only when such a data byte is accepted.
- R3: If the address byte has device bits other than 1011011, no ACK is given. All further bytes are ignored (no ACK, no register change) until the next start condition.
- R4: With sub-address bit 7 = 0, the data bytes go to consecutive slots starting at sub-address bits [2:0]. Slot 7 is followed by slot 0.
- R5: With sub-address bit 7 = 1, every data byte of the frame is written to the single slot named by bits [2:0].
- R6: Only slots 0, 1, 2, 5 and 6 hold data; writes to slots 3, 4 and 7 are acknowledged but discarded. A sub-address with any of bits [6:3] set is acknowledged, but all its data bytes are discarded.
- R7: Address byte 0xB7 is acknowledged and is followed by one status byte, sent MSB first. Bit 1 of that byte is the pilot flag, bit 0 is the SAP flag, and bits [7:2] are 0. Both flags are captured when the address is acknowledged.
- R8: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop ends reception, so bytes sent after it without a new start get no ACK and change nothing. A start restarts address reception from any state.
- R9: `agc_mode_o` always equals bits [7:6] of register slot 0 (00 = gain control off, other codes select a gain curve).
- R10: `sda_pull_o` changes only while the synchronised SCL is low, and is 0 whenever the block is not acknowledging or sending a 0 status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| pilot_det_i | input | 1 | Stereo pilot detected flag (1 = detected) |
| sap_det_i | input | 1 | Second audio carrier detected flag (1 = detected) |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release |
| agc_mode_o | output | 2 | Gain control mode, bits [7:6] of slot 0 |
| ctl_regs_o | output | 64 | Slot n on bits [8n+7:8n] |

## Verification
Embedded properties watch every cycle for several things. The SDA pull enable may only change while SCL is low. A mismatched address must leave the block ignoring the bus until a start or stop. A matched address is the only way into the address-acknowledge phase. The slot pointer must step by one, or stay put, according to the latched mode. The register bank must not move without a write strobe. The bench scenarios are the only place to show what the bus actually sees: the exact ACK pattern of each frame, wrap-around and discarded slots in the final register values, the status byte contents with its capture point, and the effect of a stop or a repeated start.

// File: rtl/tvctl_i2c_pkg.sv
package tvctl_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_now,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_c;
  logic [STAGES:0] sda_c;
  logic            scl_old;
  logic            sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_c <= '1;
      sda_c <= '1;
    end else begin
      scl_c <= {scl_c[STAGES-1:0], scl_i};
      sda_c <= {sda_c[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_c[STAGES-1];
  assign sda_now   = sda_c[STAGES-1];
  assign scl_old   = scl_c[STAGES];
  assign sda_old   = sda_c[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
  import tvctl_i2c_pkg::*;
#(
  parameter int          AW       = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_now,
  input  logic              sda_now,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              pilot_det,
  input  logic              sap_det,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  bus_state_e        state, state_n;
  logic [2:0]        bitcnt, bitcnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n;
  logic              byte_done, byte_done_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic              renew, renew_n;
  logic              sub_bad, sub_bad_n;
  logic [BYTE_W-1:0] rd_sh, rd_sh_n;
  logic              pull_q, pull_n;

  always_comb begin
    state_n     = state;
    bitcnt_n    = bitcnt;
    shreg_n     = shreg;
    byte_done_n = byte_done;
    ptr_n       = ptr;
    renew_n     = renew;
    sub_bad_n   = sub_bad;
    rd_sh_n     = rd_sh;
    wr_en       = 1'b0;
    if (start_det) begin
      state_n     = ST_ADDR;
      bitcnt_n    = '0;
      byte_done_n = 1'b0;
    end else if (stop_det) begin
      state_n     = ST_IDLE;
      byte_done_n = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (scl_rise && !byte_done) begin
            shreg_n  = {shreg[BYTE_W-2:0], sda_now};
            bitcnt_n = bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_done_n = 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done_n = 1'b0;
            bitcnt_n    = '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                state_n = ST_ADDR_ACK;
                if (shreg[0]) rd_sh_n = {{(BYTE_W-2){1'b0}}, pilot_det, sap_det};
              end else begin
                state_n = ST_IGNORE;
              end
            end else if (state == ST_SUB) begin
              state_n   = ST_SUB_ACK;
              ptr_n     = shreg[AW-1:0];
              renew_n   = shreg[7];
              sub_bad_n = |shreg[6:AW];
            end else begin
              state_n = ST_DATA_ACK;
              wr_en   = !sub_bad;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) state_n = shreg[0] ? ST_RD_BYTE : ST_SUB;
        ST_SUB_ACK:  if (scl_fall) state_n = ST_DATA;
        ST_DATA_ACK: begin
          if (scl_fall) begin
            state_n = ST_DATA;
            if (!renew) ptr_n = ptr + AW'(1);
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              state_n = ST_RD_ACK;
            end else begin
              bitcnt_n = bitcnt + 3'd1;
              rd_sh_n  = {rd_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RD_ACK:  if (scl_fall) state_n = ST_IGNORE;
        default: ;
      endcase
    end
    pull_n = (state_n == ST_ADDR_ACK) || (state_n == ST_SUB_ACK) ||
             (state_n == ST_DATA_ACK) || ((state_n == ST_RD_BYTE) && !rd_sh_n[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      ptr       <= '0;
      renew     <= 1'b0;
      sub_bad   <= 1'b0;
      rd_sh     <= '0;
      pull_q    <= 1'b0;
    end else begin
      state     <= state_n;
      bitcnt    <= bitcnt_n;
      shreg     <= shreg_n;
      byte_done <= byte_done_n;
      ptr       <= ptr_n;
      renew     <= renew_n;
      sub_bad   <= sub_bad_n;
      rd_sh     <= rd_sh_n;
      pull_q    <= pull_n;
    end
  end

  assign sda_pull = pull_q;
  assign wr_addr  = ptr;
  assign wr_data  = shreg;

  AST_PULL_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q != $past(pull_q)) |-> !scl_now); // R10
  AST_IGNORE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE && !start_det && !stop_det) |=> (state == ST_IGNORE)); // R3
  AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK) |-> (shreg[7:1] == DEV_ADDR)); // R2
  AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA_ACK && !renew) |-> (ptr == $past(ptr) + AW'(1))); // R4
  AST_RENEW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA_ACK && renew) |-> (ptr == $past(ptr))); // R5
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import tvctl_i2c_pkg::*;
#(
  parameter int                AW        = 3,
  parameter logic [(1<<AW)-1:0] IMPL_MASK = 8'h67
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [(1<<AW)*BYTE_W-1:0]   regs_flat
);
  localparam int NSLOT = 1 << AW;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (IMPL_MASK[i]) begin : g_impl
      logic [BYTE_W-1:0] q;
      logic              en;
      assign en = wr_en && (wr_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wr_data;
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = q;
    end else begin : g_empty
      assign regs_flat[i*BYTE_W +: BYTE_W] = '0;
    end
  end

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R2
endmodule

// File: rtl/tvctl_i2c_slave.sv
module tvctl_i2c_slave
  import tvctl_i2c_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          AW          = 3,
  parameter logic [6:0]  DEV_ADDR    = 7'h5B,
  parameter logic [7:0]  IMPL_MASK   = 8'h67
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        pilot_det_i,
  input  logic        sap_det_i,
  output logic        sda_pull_o,
  output logic [1:0]  agc_mode_o,
  output logic [63:0] ctl_regs_o
);
  logic scl_now, sda_now, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [(1<<AW)*BYTE_W-1:0] regs_flat;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_now(scl_now), .sda_now(sda_now), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_bus_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_now(scl_now), .sda_now(sda_now),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .pilot_det(pilot_det_i), .sap_det(sap_det_i),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ctl_regfile #(.AW(AW), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(regs_flat)
  );

  assign ctl_regs_o = 64'(regs_flat);
  assign agc_mode_o = regs_flat[7:6];

  AST_AGC_FOLLOWS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_mode_o == ctl_regs_o[7:6])); // R9
endmodule

// File: tb/sim_tvctl_i2c_slave.sv
module sim_tvctl_i2c_slave;
  localparam int Q = 4;
  localparam int H = 8;
  localparam logic [7:0] IMPL = 8'h67;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, pilot, sap;
  logic sda_pull;
  logic [1:0] agc;
  logic [63:0] regs;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pull;

  tvctl_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .pilot_det_i(pilot), .sap_det_i(sap), .sda_pull_o(sda_pull),
    .agc_mode_o(agc), .ctl_regs_o(regs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] expv [8];

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = expv[i];
    return f;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(Q); scl_m = 1'b1; waitc(H); scl_m = 1'b0; waitc(Q);
    end
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(H/2);
    ack = !sda_line; waitc(H/2); scl_m = 1'b0; waitc(Q);
  endtask

  // write frame with model update; returns 1 when the ACK pattern matched
  task automatic wr_frame(input logic [7:0] addr, input logic [7:0] sub, input int n,
                          input logic [7:0] d [4], output bit acks_ok);
    bit a;
    bit match;
    logic [2:0] p;
    match = (addr[7:1] == 7'h5B) && !addr[0];
    acks_ok = 1'b1;
    bus_start();
    send_byte(addr, a); if (a != match) acks_ok = 1'b0;
    send_byte(sub, a);  if (a != match) acks_ok = 1'b0;
    p = sub[2:0];
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a); if (a != match) acks_ok = 1'b0;
      if (match && (sub[6:3] == 4'd0) && IMPL[p]) expv[p] = d[k];
      if (!sub[7]) p = p + 3'd1;
    end
    bus_stop();
  endtask

  task automatic rd_frame(input bit flip, output bit ack, output logic [7:0] got);
    send_byte(8'hB7, ack);
    if (flip) begin pilot = ~pilot; sap = ~sap; end
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(2*Q); scl_m = 1'b1; waitc(H/2); got[i] = sda_line; waitc(H/2); scl_m = 1'b0;
    end
    waitc(Q); sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(H); scl_m = 1'b0; waitc(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] got;
    bit ok, a;
    int unsigned seed;
    seed = $urandom(32'h5EED_0123);
    for (int i = 0; i < 8; i++) expv[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pilot = 1'b0; sap = 1'b0;
    waitc(5); rst_n = 1'b1; waitc(5);

    // R1 reset state
    chk(regs == 64'd0, "R1 regs", regs, 64'd0);
    chk(sda_pull == 1'b0 && agc == 2'd0, "R1 pull/agc", {sda_pull, agc}, 0);

    // R2 / R9 basic write to slot 0
    d = '{8'hC3, 8'h00, 8'h00, 8'h00};
    wr_frame(8'hB6, 8'h00, 1, d, ok);
    chk(ok, "R2 acks", ok, 1);
    chk(regs == exp_flat(), "R2 regs", regs, exp_flat());
    chk(agc == 2'b11, "R9 agc", agc, 2'b11);

    // R4 auto-increment with wrap 7->0 (slot 7 discarded, slot 0 written)
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_frame(8'hB6, 8'h06, 3, d, ok);
    chk(ok, "R4 acks", ok, 1);
    chk(regs == exp_flat(), "R4 wrap", regs, exp_flat());
    chk(agc == expv[0][7:6], "R9 agc after wrap", agc, expv[0][7:6]);

    // R5 renewal: all bytes to slot 5, final value wins
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    wr_frame(8'hB6, 8'h85, 4, d, ok);
    chk(ok && regs[47:40] == 8'hD4, "R5 renew", regs[47:40], 8'hD4);
    chk(regs == exp_flat(), "R5 others kept", regs, exp_flat());

    // R6 unimplemented slot and out-of-range sub-address
    d = '{8'h5A, 8'h5A, 8'h5A, 8'h5A};
    wr_frame(8'hB6, 8'h83, 2, d, ok);
    chk(ok && regs == exp_flat(), "R6 slot3 discarded", regs, exp_flat());
    wr_frame(8'hB6, 8'h09, 2, d, ok);
    chk(ok && regs == exp_flat(), "R6 high sub bits discarded", regs, exp_flat());

    // R3 wrong address: no ack, nothing written
    d = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    wr_frame(8'hA6, 8'h01, 2, d, ok);
    chk(ok && regs == exp_flat(), "R3 mismatch ignored", regs, exp_flat());
    chk(sda_pull == 1'b0, "R10 released after frame", sda_pull, 0);

    // R8 bytes after stop without start
    send_byte(8'hB6, a);
    chk(!a, "R8 no ack after stop", a, 0);
    send_byte(8'h01, a); send_byte(8'h77, a);
    bus_stop();
    chk(regs == exp_flat(), "R8 no write after stop", regs, exp_flat());

    // R8 repeated start mid-frame restarts address phase
    bus_start(); send_byte(8'hB6, a); send_byte(8'h02, a);
    bus_start(); send_byte(8'hB6, a); send_byte(8'h81, a); send_byte(8'h3C, a);
    bus_stop();
    expv[1] = 8'h3C;
    chk(a && regs == exp_flat(), "R8 repeated start", regs, exp_flat());

    // R7 reads with flag capture at address ack
    pilot = 1'b1; sap = 1'b0;
    bus_start(); rd_frame(1'b1, a, got); bus_stop();
    chk(a && got == 8'h02, "R7 pilot latched", got, 8'h02);
    pilot = 1'b0; sap = 1'b1;
    bus_start(); rd_frame(1'b0, a, got); bus_stop();
    chk(a && got == 8'h01, "R7 sap", got, 8'h01);
    chk(sda_pull == 1'b0, "R10 released after read", sda_pull, 0);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [7:0] ad, sb;
      int n;
      ad = ($urandom % 6 == 0) ? {7'($urandom), 1'b0} : 8'hB6;
      sb = {1'($urandom), ($urandom % 5 == 0) ? 4'($urandom) : 4'd0, 3'($urandom)};
      n = 1 + ($urandom % 4);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      wr_frame(ad, sb, n, d, ok);
      chk(ok, sb[7] ? "R5 random acks" : "R4 random acks", ok, 1);
      chk(regs == exp_flat(), sb[7] ? "R5 random regs" : "R6 R4 random regs", regs, exp_flat());
      if (t % 4 == 0) begin
        logic [7:0] ev;
        pilot = 1'($urandom); sap = 1'($urandom);
        ev = {6'd0, pilot, sap};
        bus_start(); rd_frame(1'b1, a, got); bus_stop();
        chk(a && got == ev, "R7 random read", got, ev);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule